// File: doc/BRIEF.md
# Line-Atomic VBI and Video Output Arbiter

This block shares one byte-wide output port between two producers. One is a scaled-video stream that arrives a line at a time with a ready/valid handshake. The other is a decoded-VBI source that delivers bytes with no backpressure. VBI bytes are first collected into a one-line buffer. Only a completed line asks for the port. When granted, the line goes out as one unbroken ancillary packet, and a flag output stays high for every byte of that packet.

Arbitration is made only at line or packet boundaries, while the arbiter is idle. A pending VBI line beats a waiting video line. A video line that has begun always runs to its end. The buffer holds one line. A VBI line that arrives while the buffer is occupied (held or being sent) is thrown away and a sticky overflow output is raised.

Arbiter states: `ST_IDLE` (no grant), `ST_VIDEO` (video line granted), `ST_ANC_HDR` (six header bytes), `ST_ANC_PAY` (payload bytes). Transitions:
- `ST_IDLE` to `ST_ANC_HDR` when a line is pending.
- `ST_IDLE` to `ST_VIDEO` when no line is pending and video is valid.
- `ST_VIDEO` to `ST_IDLE` on the accepted byte marked last.
- `ST_ANC_HDR` to `ST_ANC_PAY` after header byte 5.
- `ST_ANC_PAY` to `ST_IDLE` on the last payload byte.

Buffer states: `BF_FILL` (accepting), `BF_HELD` (line complete, waiting), `BF_SEND` (draining). Transitions:
- `BF_FILL` to `BF_HELD` on an end-of-line byte of a kept line.
- `BF_HELD` to `BF_SEND` on grant.
- `BF_SEND` to `BF_FILL` on release of the last byte.

Top module: `vbi_vid_arb`

## Requirements
- R1: After reset, `out_valid`, `out_vbi_flag`, `vid_ready` and `vbi_overflow` are all 0.
- R2: A VBI packet is emitted only after its line's end-of-line byte has been written. Its bytes are 00h, FFh, FFh, then DID (default 51h), then SDID (default 0Ah), then the payload count, then the payload. `out_vbi_flag` is 1 on every packet byte.
- R3: Payload bytes appear in arrival order and unmodified, including 00h and FFh. The count byte equals the number of payload bytes.
- R4: All bytes of one packet appear on consecutive clock cycles.
- R5: When the arbiter is idle and both a VBI line and a video line are waiting, the VBI packet goes first.
- R6: A started video line is never interrupted. Its bytes appear in order with `out_vbi_flag` at 0. `vid_ready` is never 1 in the same cycle as `out_vbi_flag`.
- R7: A VBI line whose end-of-line byte arrives while the buffer is held or sending is dropped entirely, and `vbi_overflow` becomes 1 and stays 1 until reset. The next line after the buffer frees is sent normally.
- R8: Bytes beyond 255 in one VBI line are dropped and `vbi_overflow` is set. The line is sent with count FFh and its first 255 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_valid | input | 1 | Video byte valid |
| vid_data | input | 8 | Video byte |
| vid_last | input | 1 | Marks last byte of a video line |
| vid_ready | output | 1 | Video byte accepted at this edge when valid |
| vbi_valid | input | 1 | Decoded VBI byte valid (no backpressure) |
| vbi_data | input | 8 | Decoded VBI byte |
| vbi_eol | input | 1 | Marks last byte of a VBI line |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_vbi_flag | output | 1 | High while VBI packet bytes are on the port |
| vbi_overflow | output | 1 | Sticky: a VBI line or byte was dropped |

## Verification
The bench targets the following corner cases:
- Payloads dense in 00h and FFh. A design that escaped or filtered these values would shift the count and the payload.
- A VBI line that completes during a video line while the next video line is already waiting. A wrong arbiter would either cut into the running video line or let the second video line go ahead of the packet.
- A line arriving while the buffer drains. Without the drop rule this would corrupt the packet in flight, or would leave the overflow flag clear.
- A 300-byte line. This checks truncation to a count of FFh, where a wrapping counter would report a tiny count.

// File: rtl/vva_pkg.sv
package vva_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_VIDEO, ST_ANC_HDR, ST_ANC_PAY} arb_st_t;
    typedef enum logic [1:0] {BF_FILL, BF_HELD, BF_SEND} buf_st_t;
    localparam int HDR_BYTES = 6;
endpackage

// File: rtl/vva_line_buf.sv
module vva_line_buf
    import vva_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_eol,
    input  logic          grant,
    input  logic          pop,
    input  logic          release_i,
    output logic          line_rdy,
    output logic [AW-1:0] line_len,
    output logic [DW-1:0] rd_data,
    output logic          rd_last,
    output logic          ovf
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] MAXLEN = AW'(DEPTH - 1);

    buf_st_t       bst, bst_nxt;
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr, len;
    logic          disc;
    logic          busy;

    assign busy = (bst != BF_FILL);

    always_comb begin
        bst_nxt = bst;
        unique case (bst)
            BF_FILL: if (in_valid && in_eol && !disc) bst_nxt = BF_HELD;
            BF_HELD: if (grant) bst_nxt = BF_SEND;
            BF_SEND: if (release_i) bst_nxt = BF_FILL;
            default: bst_nxt = BF_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bst <= BF_FILL;
        else        bst <= bst_nxt;
    end

    always_ff @(posedge clk) begin
        if (bst == BF_FILL && in_valid && !disc && wptr != MAXLEN)
            mem[wptr] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            len  <= '0;
            disc <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            if (!busy && in_valid) begin
                if (disc) begin
                    if (in_eol) begin
                        disc <= 1'b0;
                        ovf  <= 1'b1;
                    end
                end else begin
                    if (wptr != MAXLEN) wptr <= wptr + 1'b1;
                    else                ovf  <= 1'b1;
                    if (in_eol) begin
                        len  <= (wptr == MAXLEN) ? MAXLEN : wptr + 1'b1;
                        wptr <= '0;
                    end
                end
            end
            if (busy && in_valid) begin
                if (in_eol) begin
                    ovf  <= 1'b1;
                    disc <= 1'b0;
                end else begin
                    disc <= 1'b1;
                end
            end
            if (grant)    rptr <= '0;
            else if (pop) rptr <= rptr + 1'b1;
        end
    end

    assign line_rdy = (bst == BF_HELD);
    assign line_len = len;
    assign rd_data  = mem[rptr];
    assign rd_last  = (rptr == len - 1'b1);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf) |-> ovf);

    // R4
    release_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> (bst == BF_SEND));
endmodule

// File: rtl/vva_out_fsm.sv
module vva_out_fsm
    import vva_pkg::*;
#(
    parameter int          DW   = 8,
    parameter int          AW   = 8,
    parameter logic [7:0]  DID  = 8'h51,
    parameter logic [7:0]  SDID = 8'h0A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_rdy,
    input  logic [AW-1:0] line_len,
    input  logic [DW-1:0] rd_data,
    input  logic          rd_last,
    input  logic          vid_valid,
    input  logic [DW-1:0] vid_data,
    input  logic          vid_last,
    output logic          vid_ready,
    output logic          grant,
    output logic          pop,
    output logic          release_o,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_flag
);
    localparam int HCW = $clog2(HDR_BYTES);
    localparam logic [HCW-1:0] HLAST = HCW'(HDR_BYTES - 1);

    arb_st_t        st, st_nxt;
    logic [HCW-1:0] hcnt;
    logic [DW-1:0]  hdr_b;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:    if (line_rdy)               st_nxt = ST_ANC_HDR;
                        else if (vid_valid)         st_nxt = ST_VIDEO;
            ST_VIDEO:   if (vid_valid && vid_last)  st_nxt = ST_IDLE;
            ST_ANC_HDR: if (hcnt == HLAST)          st_nxt = ST_ANC_PAY;
            ST_ANC_PAY: if (rd_last)                st_nxt = ST_IDLE;
            default:                                st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            hcnt <= '0;
        end else begin
            st   <= st_nxt;
            hcnt <= (st == ST_ANC_HDR) ? hcnt + 1'b1 : '0;
        end
    end

    assign vid_ready = (st == ST_VIDEO);
    assign grant     = (st == ST_IDLE) && line_rdy;
    assign pop       = (st == ST_ANC_PAY);
    assign release_o = (st == ST_ANC_PAY) && rd_last;

    always_comb begin
        case (hcnt)
            3'd0:    hdr_b = 8'h00;
            3'd1:    hdr_b = 8'hFF;
            3'd2:    hdr_b = 8'hFF;
            3'd3:    hdr_b = DID;
            3'd4:    hdr_b = SDID;
            default: hdr_b = DW'(line_len);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_flag  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_flag  <= 1'b0;
            unique case (st)
                ST_IDLE: ;
                ST_VIDEO: if (vid_valid) begin
                    out_valid <= 1'b1;
                    out_data  <= vid_data;
                end
                ST_ANC_HDR: begin
                    out_valid <= 1'b1;
                    out_flag  <= 1'b1;
                    out_data  <= hdr_b;
                end
                ST_ANC_PAY: begin
                    out_valid <= 1'b1;
                    out_flag  <= 1'b1;
                    out_data  <= rd_data;
                end
                default: ;
            endcase
        end
    end

    // R2
    hdr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_flag) |-> (out_valid && out_data == 8'h00));

    // R5
    vbi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && line_rdy && vid_valid) |=> !vid_ready);
endmodule

// File: rtl/vbi_vid_arb.sv
module vbi_vid_arb #(
    parameter int         DW   = 8,
    parameter int         AW   = 8,
    parameter logic [7:0] DID  = 8'h51,
    parameter logic [7:0] SDID = 8'h0A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vid_valid,
    input  logic [DW-1:0] vid_data,
    input  logic          vid_last,
    output logic          vid_ready,
    input  logic          vbi_valid,
    input  logic [DW-1:0] vbi_data,
    input  logic          vbi_eol,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_vbi_flag,
    output logic          vbi_overflow
);
    logic          line_rdy, rd_last, grant, pop, rel;
    logic [AW-1:0] line_len;
    logic [DW-1:0] rd_data;

    vva_line_buf #(.DW(DW), .AW(AW)) i_buf (
        .clk(clk), .rst_n(rst_n),
        .in_valid(vbi_valid), .in_data(vbi_data), .in_eol(vbi_eol),
        .grant(grant), .pop(pop), .release_i(rel),
        .line_rdy(line_rdy), .line_len(line_len),
        .rd_data(rd_data), .rd_last(rd_last), .ovf(vbi_overflow)
    );

    vva_out_fsm #(.DW(DW), .AW(AW), .DID(DID), .SDID(SDID)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .line_rdy(line_rdy), .line_len(line_len),
        .rd_data(rd_data), .rd_last(rd_last),
        .vid_valid(vid_valid), .vid_data(vid_data), .vid_last(vid_last),
        .vid_ready(vid_ready), .grant(grant), .pop(pop), .release_o(rel),
        .out_valid(out_valid), .out_data(out_data), .out_flag(out_vbi_flag)
    );

    // R6
    no_flag_in_video_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_vbi_flag && vid_ready));
endmodule

// File: tb/test_vbi_vid_arb.sv
`timescale 1ns/1ps
module test_vbi_vid_arb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vid_valid = 1'b0, vid_last = 1'b0, vid_ready;
    logic [7:0] vid_data = '0;
    logic       vbi_valid = 1'b0, vbi_eol = 1'b0;
    logic [7:0] vbi_data = '0;
    logic       out_valid, out_vbi_flag, vbi_overflow;
    logic [7:0] out_data;

    localparam logic [7:0] DID_V  = 8'h51;
    localparam logic [7:0] SDID_V = 8'h0A;

    always #2.5 clk = ~clk;

    vbi_vid_arb i_vbi_vid_arb (
        .clk(clk), .rst_n(rst_n),
        .vid_valid(vid_valid), .vid_data(vid_data), .vid_last(vid_last),
        .vid_ready(vid_ready),
        .vbi_valid(vbi_valid), .vbi_data(vbi_data), .vbi_eol(vbi_eol),
        .out_valid(out_valid), .out_data(out_data),
        .out_vbi_flag(out_vbi_flag), .vbi_overflow(vbi_overflow)
    );

    int     n_chk = 0, n_bad = 0;
    longint cyc = 0;
    bit     finished = 0;
    logic [7:0] obs_d[$];
    logic       obs_f[$];
    longint     obs_c[$];
    logic [7:0] ex_d[$];
    logic       ex_f[$];
    logic       ex_s[$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            obs_d.push_back(out_data);
            obs_f.push_back(out_vbi_flag);
            obs_c.push_back(cyc);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic add_pkt(input logic [7:0] p[$]);
        int n = (p.size() > 255) ? 255 : p.size();
        logic [7:0] h[6];
        h[0] = 8'h00; h[1] = 8'hFF; h[2] = 8'hFF;
        h[3] = DID_V; h[4] = SDID_V; h[5] = 8'(n);
        for (int i = 0; i < 6; i++) begin
            ex_d.push_back(h[i]); ex_f.push_back(1'b1); ex_s.push_back(i == 0);
        end
        for (int i = 0; i < n; i++) begin
            ex_d.push_back(p[i]); ex_f.push_back(1'b1); ex_s.push_back(1'b0);
        end
    endtask

    task automatic add_vid(input logic [7:0] p[$]);
        for (int i = 0; i < p.size(); i++) begin
            ex_d.push_back(p[i]); ex_f.push_back(1'b0); ex_s.push_back(1'b0);
        end
    endtask

    task automatic expect_out(input string req);
        int t = 0;
        int bad_i;
        while (obs_d.size() < ex_d.size() && t < 4000) begin
            @(negedge clk); t++;
        end
        repeat (20) @(negedge clk);
        chk(obs_d.size() == ex_d.size(), req, "byte count", obs_d.size(), ex_d.size());
        bad_i = -1;
        for (int i = 0; i < ex_d.size() && i < obs_d.size(); i++)
            if (bad_i < 0 && obs_d[i] !== ex_d[i]) bad_i = i;
        if (bad_i >= 0) chk(0, req, $sformatf("data @%0d", bad_i), obs_d[bad_i], ex_d[bad_i]);
        else            chk(1, req, "data", 0, 0);
        bad_i = -1;
        for (int i = 0; i < ex_f.size() && i < obs_f.size(); i++)
            if (bad_i < 0 && obs_f[i] !== ex_f[i]) bad_i = i;
        if (bad_i >= 0) chk(0, req, $sformatf("flag @%0d", bad_i), obs_f[bad_i], ex_f[bad_i]);
        else            chk(1, req, "flag", 0, 0);
        // R4 packet bytes back to back
        bad_i = -1;
        for (int i = 1; i < ex_f.size() && i < obs_c.size(); i++)
            if (bad_i < 0 && ex_f[i] && !ex_s[i] && obs_c[i] != obs_c[i-1] + 1) bad_i = i;
        if (bad_i >= 0) chk(0, "R4", $sformatf("gap @%0d", bad_i), obs_c[bad_i] - obs_c[bad_i-1], 1);
        else            chk(1, "R4", "contiguous", 0, 0);
        obs_d.delete(); obs_f.delete(); obs_c.delete();
        ex_d.delete(); ex_f.delete(); ex_s.delete();
    endtask

    task automatic send_vbi(input logic [7:0] p[$]);
        for (int i = 0; i < p.size(); i++) begin
            vbi_valid = 1'b1; vbi_data = p[i]; vbi_eol = (i == p.size() - 1);
            @(negedge clk);
        end
        vbi_valid = 1'b0; vbi_eol = 1'b0;
    endtask

    task automatic send_vid(input logic [7:0] p[$], input bit hold);
        bit ok;
        for (int i = 0; i < p.size(); i++) begin
            vid_valid = 1'b1; vid_data = p[i]; vid_last = (i == p.size() - 1);
            do begin
                ok = vid_ready;
                @(negedge clk);
            end while (!ok);
        end
        if (!hold) begin
            vid_valid = 1'b0; vid_last = 1'b0;
        end
    endtask

    function automatic logic [7:0] rnd_byte();
        int k = $urandom_range(0, 3);
        if (k == 0) return 8'h00;
        if (k == 1) return 8'hFF;
        return 8'($urandom_range(0, 255));
    endfunction

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] a[$], b[$], l[$];
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4711);
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(out_valid == 0 && out_vbi_flag == 0, "R1", "out valid/flag", {out_valid, out_vbi_flag}, 0);
        chk(vid_ready == 0, "R1", "vid_ready", vid_ready, 0);
        chk(vbi_overflow == 0, "R1", "overflow", vbi_overflow, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3: nothing before eol, then full packet with 00/FF payload
        l = '{8'h00, 8'hFF, 8'h00, 8'h12, 8'hFF, 8'hFF, 8'h00, 8'h7E};
        for (int i = 0; i < 7; i++) begin
            vbi_valid = 1'b1; vbi_data = l[i]; vbi_eol = 1'b0; @(negedge clk);
        end
        vbi_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk(obs_d.size() == 0, "R2", "output before eol", obs_d.size(), 0);
        vbi_valid = 1'b1; vbi_data = l[7]; vbi_eol = 1'b1; @(negedge clk);
        vbi_valid = 1'b0; vbi_eol = 1'b0;
        add_pkt(l);
        expect_out("R3");

        // R5 R6: VBI completes during video line A while B waits
        a.delete(); b.delete(); l.delete();
        for (int i = 0; i < 20; i++) a.push_back(8'(8'h20 + i));
        for (int i = 0; i < 6; i++)  b.push_back(8'(8'h80 + i));
        for (int i = 0; i < 5; i++)  l.push_back(8'(8'hA0 + i));
        fork
            begin send_vid(a, 1); send_vid(b, 0); end
            begin repeat (3) @(negedge clk); send_vbi(l); end
        join
        add_vid(a); add_pkt(l); add_vid(b);
        expect_out("R5");

        // constrained random single transactions
        for (int it = 0; it < 40; it++) begin
            l.delete();
            if ($urandom_range(0, 1) == 1) begin
                int n = $urandom_range(1, 40);
                for (int i = 0; i < n; i++) l.push_back(rnd_byte());
                send_vbi(l); add_pkt(l);
                expect_out("R3");
            end else begin
                int n = $urandom_range(1, 30);
                for (int i = 0; i < n; i++) l.push_back(8'($urandom_range(0, 255)));
                send_vid(l, 0); add_vid(l);
                expect_out("R6");
            end
        end
        chk(vbi_overflow == 0, "R7", "no overflow yet", vbi_overflow, 0);

        // R7: line finishing during drain is dropped
        a.delete(); b.delete(); l.delete();
        for (int i = 0; i < 30; i++) a.push_back(rnd_byte());
        for (int i = 0; i < 4; i++)  b.push_back(8'hC0);
        for (int i = 0; i < 3; i++)  l.push_back(8'(8'hD0 + i));
        send_vbi(a);
        while (!out_vbi_flag) @(negedge clk);
        send_vbi(b);
        add_pkt(a);
        expect_out("R7");
        chk(vbi_overflow == 1, "R7", "overflow set", vbi_overflow, 1);
        send_vbi(l); add_pkt(l);
        expect_out("R7");
        chk(vbi_overflow == 1, "R7", "overflow sticky", vbi_overflow, 1);

        // R8: 300-byte line truncated to 255
        rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk(vbi_overflow == 0, "R1", "overflow after reset", vbi_overflow, 0);
        l.delete();
        for (int i = 0; i < 300; i++) l.push_back(8'(i * 7));
        send_vbi(l); add_pkt(l);
        expect_out("R8");
        chk(vbi_overflow == 1, "R8", "overflow on long line", vbi_overflow, 1);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule